// File: doc/BRIEF.md
# Supervisor Mode and Watchdog Controller

This block is the supervisory core of a system-basis supervisor. It keeps the operating mode as a two-bit code: Init after power-on, Normal for regular work, Stop for low power, and Restart while a watchdog-caused reset is in progress. It drives an active-low reset pin toward the host processor. That pin stays low while the supply comparator reports the supply as bad, and it is released only after a programmable delay. A window watchdog guards the host. After every release the watchdog starts with a long open window. After each accepted trigger it switches to a closed/open window pair.

A missing trigger, or a trigger that arrives in the closed part of the window, is a watchdog failure. A failure enters Restart and fires one reset pulse. The fail-safe outputs are driven active from the failure until the next accepted trigger. A limit bit can cap the number of back-to-back watchdog resets at three. After that, further failures leave the mode unchanged. Wake events on enabled lines raise a one-cycle interrupt in Normal mode. A test bit lets software force the fail-safe outputs while in Normal mode.

Top module: `sbc_supervisor`

## Requirements
- R1: While `por_n` is low, `mode` is Init (2'b00), `ro_n` is 0, `int_o` is 0 and `fo_en` is all zeros.
- R2: `ro_n` is 0 in every cycle after a clock edge that samples `vcc_ok` low. Once `vcc_ok` is high, `ro_n` stays 0 through the first `rst_dly` edges and rises at edge `rst_dly`+1.
- R3: Mode codes are Init 2'b00, Normal 2'b01, Stop 2'b10 and Restart 2'b11. In Init, a strobe on `spi_cmd` or on `stop_req` moves the mode to Normal at that edge.
- R4: After `ro_n` is released, a trigger-free stretch of LONG_WIN watchdog cycles is a failure. At the LONG_WIN-th edge the mode becomes Restart and `ro_n` goes low.
- R5: After an accepted trigger at edge T, a trigger at T+1..T+WIN_CLOSED is a failure. A trigger at T+WIN_CLOSED+1..T+WIN_CLOSED+WIN_OPEN is accepted. Having no trigger by T+WIN_CLOSED+WIN_OPEN is a failure at that edge.
- R6: A reset event at edge F holds `ro_n` low up to and including edge F+PULSE_LEN+`rst_dly`. `ro_n` rises at the next edge, and the mode returns to Normal one edge later with a fresh long window.
- R7: With `max3_en` set, once three consecutive watchdog resets have occurred, later failures produce no reset and leave the mode unchanged.
- R8: With `max3_en` clear, every watchdog failure produces one reset event, with no limit.
- R9: An accepted trigger clears the consecutive-failure count, so the next failure resets again even under `max3_en`.
- R10: In Normal mode, a `wake` bit whose `wake_en` bit is set makes `int_o` high for exactly the cycle after the edge that samples it, and the mode is unchanged. Wake bits that are not enabled raise nothing.
- R11: Wake events sampled in Init raise no interrupt, then or later.
- R12: `fo_test` drives all `fo_en` bits to 1 only while the mode is Normal. Clearing it releases them.
- R13: A watchdog failure sets all `fo_en` bits until the next accepted trigger. While the supply has never been good, `fo_en` stays all zeros.
- R14: In Normal, `stop_req` enters Stop. In Stop, `spi_cmd` returns to Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| spi_cmd | input | 1 | Strobe: any decoded SPI command, legal or illegal |
| stop_req | input | 1 | Strobe: SPI request to enter Stop |
| wd_trig | input | 1 | Strobe: watchdog trigger |
| wake | input | WAKE_W | Wake event lines (bus and wake pin) |
| wake_en | input | WAKE_W | Per-line wake-capable enables |
| vcc_ok | input | 1 | Supply above reset threshold |
| max3_en | input | 1 | Cap consecutive watchdog resets at three |
| fo_test | input | 1 | Fail-safe output test bit |
| rst_dly | input | DLY_W | Reset release delay in cycles |
| mode | output | 2 | Operating mode code |
| ro_n | output | 1 | Reset output, active low |
| int_o | output | 1 | Interrupt pulse |
| fo_en | output | FO_N | Fail-safe output enables |

## Verification
A wrong watchdog count shows up as a mode change to Restart and a falling `ro_n` one edge earlier or later than the window arithmetic predicts. The bench therefore samples both signals on either side of each boundary edge. A consecutive-failure count that is wrong, or that is never cleared, changes how many `ro_n` falling edges occur in a long run without triggers. That error appears within about four failure periods. A release counter that is off by one moves the `ro_n` rising edge. A stale mode shows in the interrupt and fail-safe enables in the very next cycle.

// File: rtl/sbc_supervisor.sv
module sbc_supervisor #(
  parameter int LONG_WIN   = 64,
  parameter int WIN_CLOSED = 8,
  parameter int WIN_OPEN   = 16,
  parameter int PULSE_LEN  = 4,
  parameter int DLY_W      = 8,
  parameter int WAKE_W     = 6,
  parameter int FO_N       = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              spi_cmd,
  input  logic              stop_req,
  input  logic              wd_trig,
  input  logic [WAKE_W-1:0] wake,
  input  logic [WAKE_W-1:0] wake_en,
  input  logic              vcc_ok,
  input  logic              max3_en,
  input  logic              fo_test,
  input  logic [DLY_W-1:0]  rst_dly,
  output logic [1:0]        mode,
  output logic              ro_n,
  output logic              int_o,
  output logic [FO_N-1:0]   fo_en
);
  localparam int WIN_LEN = WIN_CLOSED + WIN_OPEN;
  localparam int CNT_MAX = (LONG_WIN > WIN_LEN) ? LONG_WIN : WIN_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PC_W    = $clog2(PULSE_LEN + 1);

  localparam logic [1:0] M_INIT    = 2'b00;
  localparam logic [1:0] M_NORMAL  = 2'b01;
  localparam logic [1:0] M_STOP    = 2'b10;
  localparam logic [1:0] M_RESTART = 2'b11;

  logic [1:0]       mode_q;
  logic             ro_q, int_q, fo_fail_q, long_q;
  logic [CNT_W-1:0] wd_cnt;
  logic [1:0]       fail_cnt;
  logic [PC_W-1:0]  pcnt;
  logic [DLY_W-1:0] dcnt;

  logic wd_run, early, expire, trig_ok, wd_fail, rst_evt;

  assign wd_run  = ro_q && (mode_q != M_RESTART);
  assign early   = !long_q && wd_trig && (wd_cnt < CNT_W'(WIN_CLOSED));
  assign expire  = !wd_trig &&
                   (wd_cnt == (long_q ? CNT_W'(LONG_WIN - 1) : CNT_W'(WIN_LEN - 1)));
  assign trig_ok = wd_run && wd_trig && !early;
  assign wd_fail = wd_run && (early || expire);
  assign rst_evt = wd_fail && !(max3_en && fail_cnt == 2'd3);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wd_cnt <= '0;
      long_q <= 1'b1;
    end else if (!wd_run || wd_fail) begin
      wd_cnt <= '0;
      long_q <= 1'b1;
    end else if (trig_ok) begin
      wd_cnt <= '0;
      long_q <= 1'b0;
    end else begin
      wd_cnt <= wd_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fail_cnt  <= '0;
      fo_fail_q <= 1'b0;
    end else if (wd_fail) begin
      if (fail_cnt != 2'd3) fail_cnt <= fail_cnt + 2'd1;
      fo_fail_q <= 1'b1;
    end else if (trig_ok) begin
      fail_cnt  <= '0;
      fo_fail_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ro_q <= 1'b0;
      pcnt <= '0;
      dcnt <= '0;
    end else if (!vcc_ok) begin
      ro_q <= 1'b0;
      pcnt <= '0;
      dcnt <= '0;
    end else if (rst_evt) begin
      ro_q <= 1'b0;
      pcnt <= PC_W'(PULSE_LEN);
      dcnt <= '0;
    end else if (pcnt != '0) begin
      pcnt <= pcnt - PC_W'(1);
    end else if (dcnt != rst_dly) begin
      dcnt <= dcnt + DLY_W'(1);
    end else begin
      ro_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= M_INIT;
    end else if (rst_evt) begin
      mode_q <= M_RESTART;
    end else begin
      unique case (mode_q)
        M_INIT:    if (spi_cmd || stop_req) mode_q <= M_NORMAL;
        M_NORMAL:  if (stop_req) mode_q <= M_STOP;
        M_STOP:    if (spi_cmd) mode_q <= M_NORMAL;
        M_RESTART: if (ro_q) mode_q <= M_NORMAL;
        default:   mode_q <= M_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) int_q <= 1'b0;
    else        int_q <= (mode_q == M_NORMAL) && |(wake & wake_en);
  end

  assign mode  = mode_q;
  assign ro_n  = ro_q;
  assign int_o = int_q;
  assign fo_en = {FO_N{fo_fail_q || (fo_test && mode_q == M_NORMAL)}};
endmodule

module sbc_supervisor_chk #(
  parameter int FO_N = 3
) (
  input logic            clk,
  input logic            por_n,
  input logic            vcc_ok,
  input logic            spi_cmd,
  input logic [1:0]      mode,
  input logic            ro_n,
  input logic            int_o,
  input logic [FO_N-1:0] fo_en
);
  p_ro_held_r2: assert property (@(posedge clk) disable iff (!por_n)
    !vcc_ok |=> !ro_n);

  p_init_exit_r3: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b00 && spi_cmd) |=> (mode == 2'b01 || mode == 2'b11));

  p_restart_low_r6: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b11 && $past(mode) != 2'b11) |-> !ro_n);

  p_int_normal_r10: assert property (@(posedge clk) disable iff (!por_n)
    int_o |-> $past(mode) == 2'b01);

  p_fo_quiet_init_r13: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'b00) |-> (fo_en == '0));
endmodule

bind sbc_supervisor sbc_supervisor_chk #(.FO_N(FO_N)) u_chk (
  .clk(clk), .por_n(por_n), .vcc_ok(vcc_ok), .spi_cmd(spi_cmd),
  .mode(mode), .ro_n(ro_n), .int_o(int_o), .fo_en(fo_en)
);

// File: tb/sbc_supervisor_tb.sv
module sbc_supervisor_tb;
  localparam int LW = 64;
  localparam int CL = 8;
  localparam int OP = 16;
  localparam int PL = 4;
  localparam int D  = 5;

  logic clk = 1'b0;
  logic por_n, spi_cmd, stop_req, wd_trig, vcc_ok, max3_en, fo_test;
  logic [5:0] wake, wake_en;
  logic [7:0] rst_dly;
  logic [1:0] mode;
  logic ro_n, int_o;
  logic [2:0] fo_en;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sbc_supervisor u_dut (
    .clk(clk), .por_n(por_n), .spi_cmd(spi_cmd), .stop_req(stop_req),
    .wd_trig(wd_trig), .wake(wake), .wake_en(wake_en), .vcc_ok(vcc_ok),
    .max3_en(max3_en), .fo_test(fo_test), .rst_dly(rst_dly),
    .mode(mode), .ro_n(ro_n), .int_o(int_o), .fo_en(fo_en)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic power_up(input logic lim);
    por_n = 0; vcc_ok = 0; spi_cmd = 0; stop_req = 0; wd_trig = 0;
    wake = '0; wake_en = '0; max3_en = lim; fo_test = 0; rst_dly = 8'(D);
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    vcc_ok = 1;
    repeat (D) @(negedge clk);
    chk_eq("R2 ro_n before delay end", int'(ro_n), 0);
    @(negedge clk);
    chk_eq("R2 ro_n released", int'(ro_n), 1);
  endtask

  task automatic spi_pulse();
    spi_cmd = 1; @(negedge clk); spi_cmd = 0;
  endtask

  task automatic stop_pulse();
    stop_req = 1; @(negedge clk); stop_req = 0;
  endtask

  task automatic trig_pulse();
    wd_trig = 1; @(negedge clk); wd_trig = 0;
  endtask

  task automatic trig_after(input int k);
    repeat (k - 1) @(negedge clk);
    trig_pulse();
  endtask

  task automatic wake_pulse(input logic [5:0] v);
    wake = v; @(negedge clk); wake = '0;
  endtask

  task automatic count_resets(input int n, output int cnt);
    logic prev;
    cnt = 0;
    prev = ro_n;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (prev && !ro_n) cnt++;
      prev = ro_n;
    end
  endtask

  task automatic t_reset();
    por_n = 0; vcc_ok = 0; spi_cmd = 0; stop_req = 0; wd_trig = 0;
    wake = '0; wake_en = '0; max3_en = 0; fo_test = 0; rst_dly = 8'(D);
    repeat (3) @(negedge clk);
    chk_eq("R1 mode", int'(mode), 0);
    chk_eq("R1 ro_n", int'(ro_n), 0);
    chk_eq("R1 int_o", int'(int_o), 0);
    chk_eq("R1 fo_en", int'(fo_en), 0);
    por_n = 1;
    repeat (100) @(negedge clk);
    chk_eq("R2 ro_n with supply low", int'(ro_n), 0);
    chk_eq("R13 fo_en with supply low", int'(fo_en), 0);
    chk_eq("R13 mode with supply low", int'(mode), 0);
  endtask

  task automatic t_init_exit();
    power_up(0);
    spi_pulse();
    chk_eq("R3 spi_cmd leaves Init", int'(mode), 1);
    power_up(0);
    stop_pulse();
    chk_eq("R3 stop_req in Init goes Normal", int'(mode), 1);
  endtask

  task automatic t_long_window();
    power_up(0);
    repeat (LW - 1) @(negedge clk);
    chk_eq("R4 still Init before window end", int'(mode), 0);
    @(negedge clk);
    chk_eq("R4 Restart at window end", int'(mode), 3);
    chk_eq("R4 reset asserted", int'(ro_n), 0);
    chk_eq("R13 fail-safe on failure", int'(fo_en), 7);
    repeat (PL + D) @(negedge clk);
    chk_eq("R6 ro_n low through delay", int'(ro_n), 0);
    @(negedge clk);
    chk_eq("R6 ro_n released", int'(ro_n), 1);
    chk_eq("R6 still Restart", int'(mode), 3);
    @(negedge clk);
    chk_eq("R6 back to Normal", int'(mode), 1);
    repeat (LW - 1) @(negedge clk);
    chk_eq("R6 new long window", int'(mode), 1);
    @(negedge clk);
    chk_eq("R8 second failure resets", int'(mode), 3);
  endtask

  task automatic t_window();
    power_up(0);
    spi_pulse();
    trig_pulse();
    chk_eq("R5 trigger in long window", int'(mode), 1);
    chk_eq("R13 fail-safe off", int'(fo_en), 0);
    trig_after(CL + 1);
    chk_eq("R5 first open cycle accepted", int'(mode), 1);
    trig_after(CL + OP);
    chk_eq("R5 last open cycle accepted", int'(mode), 1);
    trig_after(CL);
    chk_eq("R5 closed-window trigger fails", int'(mode), 3);
    power_up(0);
    spi_pulse();
    trig_pulse();
    repeat (CL + OP - 1) @(negedge clk);
    chk_eq("R5 open window not yet expired", int'(mode), 1);
    @(negedge clk);
    chk_eq("R5 open window expiry fails", int'(mode), 3);
  endtask

  task automatic t_limit();
    int n;
    power_up(1);
    spi_pulse();
    count_resets(8 * (LW + PL + D + 2), n);
    chk_eq("R7 resets capped", n, 3);
    chk_eq("R7 mode kept", int'(mode), 1);
    chk_eq("R13 fail-safe held", int'(fo_en), 7);
    trig_pulse();
    chk_eq("R13 fail-safe cleared by trigger", int'(fo_en), 0);
    count_resets(CL + OP + 2, n);
    chk_eq("R9 count cleared, reset again", n, 1);
  endtask

  task automatic t_nolimit();
    int n;
    power_up(0);
    spi_pulse();
    count_resets(8 * (LW + PL + D + 2), n);
    chk(n > 3, "R8 resets unlimited", n, 4);
  endtask

  task automatic t_wake();
    power_up(0);
    wake_en = 6'b000011;
    wake_pulse(6'b000001);
    chk_eq("R11 no interrupt in Init", int'(int_o), 0);
    spi_pulse();
    chk_eq("R11 Init wake dropped", int'(int_o), 0);
    @(negedge clk);
    chk_eq("R11 Init wake dropped later", int'(int_o), 0);
    wake_pulse(6'b000010);
    chk_eq("R10 interrupt raised", int'(int_o), 1);
    chk_eq("R10 mode unchanged", int'(mode), 1);
    @(negedge clk);
    chk_eq("R10 interrupt one cycle", int'(int_o), 0);
    wake_pulse(6'b010000);
    chk_eq("R10 disabled line ignored", int'(int_o), 0);
  endtask

  task automatic t_fo_test();
    power_up(0);
    fo_test = 1;
    @(negedge clk);
    chk_eq("R12 test bit ignored in Init", int'(fo_en), 0);
    spi_pulse();
    chk_eq("R12 test bit in Normal", int'(fo_en), 7);
    fo_test = 0;
    @(negedge clk);
    chk_eq("R12 test bit cleared", int'(fo_en), 0);
  endtask

  task automatic t_stop();
    power_up(0);
    spi_pulse();
    stop_pulse();
    chk_eq("R14 enter Stop", int'(mode), 2);
    spi_pulse();
    chk_eq("R14 leave Stop", int'(mode), 1);
  endtask

  initial begin
    por_n = 0; vcc_ok = 0; spi_cmd = 0; stop_req = 0; wd_trig = 0;
    wake = '0; wake_en = '0; max3_en = 0; fo_test = 0; rst_dly = 8'(D);
    t_reset();
    t_init_exit();
    t_long_window();
    t_window();
    t_limit();
    t_nolimit();
    t_wake();
    t_fo_test();
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule